// File: doc/BRIEF.md
# Per-Core Reset Sequencer

This block drives the resets of two protocol cores that share one board reset pin but can also be reset one at a time. For each core it takes three active-low request inputs: a cold request, a warm request and a PHY-clear request. It drives three active-low reset outputs for that core: one for the sticky-register domain, one for the port controller and one for the PHY layer. It also drives an active-low reset-status output that goes high once the core is fully out of reset.

The board pin always wins. While it is low, every reset output and every status output is low. Once it has been released and the sequence has run, each core can be reset on its own. A cold reset clears the sticky domain as well as the controller and PHY. A warm reset leaves the sticky domain running. A PHY clear resets only the PHY layer. A core ignores its requests while its status output is low. A reset of one core never disturbs the other core.

Top module: `core_rst_seq`

## Requirements
- R1: While `board_rst_n` is low, every bit of `sticky_rst_n`, `ctrl_rst_n`, `phy_rst_n` and `rst_stat_n` is low. This takes effect asynchronously, without waiting for a clock edge.
- R2: After `board_rst_n` rises, the pin passes through a two-flop synchronizer. The sticky, controller and PHY resets of both cores then rise on the 18th rising clock edge, and `rst_stat_n` rises on the 26th.
- R3: A falling edge on `cold_req_n[c]` drives all three resets of core c low on the 3rd rising edge after the input falls.
- R4: A falling edge on `warm_req_n[c]` drives `ctrl_rst_n[c]` and `phy_rst_n[c]` low on the 3rd rising edge. `sticky_rst_n[c]` stays high.
- R5: A falling edge on `phyclr_req_n[c]` drives only `phy_rst_n[c]` low on the 3rd rising edge.
- R6: When several request kinds of one core fall in the same cycle, cold beats warm and warm beats PHY clear.
- R7: Once a per-core reset begins, its outputs stay low for 16 cycles. If the request has already risen, they rise on the 16th edge after they fell.
- R8: If the request is still low after 16 cycles, the outputs stay low. They rise on the 3rd rising edge after the request input rises.
- R9: `rst_stat_n[c]` goes low in the same cycle as the first reset of a per-core reset. It rises 8 edges after that core's resets rise.
- R10: Any request for core c whose falling edge arrives while `rst_stat_n[c]` is low has no effect on the outputs of core c.
- R11: A reset of one core leaves the outputs of the other core unchanged.
- R12: The outputs are nested. A low sticky reset implies a low controller reset, which implies a low PHY reset, which implies a low status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| board_rst_n | input | 1 | Shared board reset, active low, asynchronous |
| cold_req_n | input | NUM_CORES | Per-core cold reset request, active low |
| warm_req_n | input | NUM_CORES | Per-core warm reset request, active low |
| phyclr_req_n | input | NUM_CORES | Per-core PHY-clear request, active low |
| sticky_rst_n | output | NUM_CORES | Sticky-domain reset, active low |
| ctrl_rst_n | output | NUM_CORES | Port controller reset, active low |
| phy_rst_n | output | NUM_CORES | PHY layer reset, active low |
| rst_stat_n | output | NUM_CORES | Core out of reset when high |

## Verification
A request input that falls shows up on the outputs on the 3rd rising edge: two synchronizer edges, then one output register. The resets rise 16 edges later, and the status rises 8 edges after that. After the board pin rises, the resets are due on edge 18 and the status on edge 26. The bench changes inputs on falling clock edges and counts whole falling edges up to each due cycle. It checks one cycle before and on the due cycle, so that an early or a late release both show up.

// File: rtl/core_rst_seq_pkg.sv
package core_rst_seq_pkg;
  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_HOLD   = 2'd1,
    PH_SETTLE = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    K_COLD = 2'd0,
    K_WARM = 2'd1,
    K_PHY  = 2'd2
  } kind_e;
endpackage

// File: rtl/crs_rst_sync.sv
module crs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/crs_req_sync.sv
module crs_req_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '1;
    else        stage_q <= stage_d;
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/crs_core_seq.sv
module crs_core_seq
  import core_rst_seq_pkg::*;
#(
  parameter int HOLD_CYC   = 16,
  parameter int STATUS_DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cold_s_n,
  input  logic warm_s_n,
  input  logic phy_s_n,
  output logic sticky_rst_n,
  output logic ctrl_rst_n,
  output logic phy_rst_n,
  output logic stat_n
);
  localparam int CNT_MAX = (HOLD_CYC > STATUS_DLY) ? HOLD_CYC : STATUS_DLY;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(STATUS_DLY - 1);

  phase_e        phase_q, phase_d;
  kind_e         kind_q, kind_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [2:0]    prev_q;
  logic [2:0]    cur;
  logic [2:0]    fall;
  logic          hold_req;
  logic          sticky_d, ctrl_d, phy_d, stat_d;

  assign cur  = {phy_s_n, warm_s_n, cold_s_n};
  assign fall = prev_q & ~cur;

  always_comb begin
    unique case (kind_q)
      K_COLD:  hold_req = !cold_s_n;
      K_WARM:  hold_req = !warm_s_n;
      default: hold_req = !phy_s_n;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (phase_q)
      PH_RUN: begin
        if (fall[0]) begin
          phase_d = PH_HOLD; kind_d = K_COLD; cnt_d = '0; cnt_en = 1'b1;
        end else if (fall[1]) begin
          phase_d = PH_HOLD; kind_d = K_WARM; cnt_d = '0; cnt_en = 1'b1;
        end else if (fall[2]) begin
          phase_d = PH_HOLD; kind_d = K_PHY;  cnt_d = '0; cnt_en = 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == HOLD_LAST) begin
          if (!hold_req) begin
            phase_d = PH_SETTLE; cnt_d = '0; cnt_en = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1; cnt_en = 1'b1;
        end
      end
      PH_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          phase_d = PH_RUN;
        end else begin
          cnt_d = cnt_q + 1'b1; cnt_en = 1'b1;
        end
      end
      default: begin
        phase_d = PH_HOLD; kind_d = K_COLD; cnt_d = '0; cnt_en = 1'b1;
      end
    endcase
  end

  always_comb begin
    sticky_d = !((phase_d == PH_HOLD) && (kind_d == K_COLD));
    ctrl_d   = !((phase_d == PH_HOLD) && (kind_d != K_PHY));
    phy_d    = (phase_d != PH_HOLD);
    stat_d   = (phase_d == PH_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_HOLD;
      kind_q       <= K_COLD;
      cnt_q        <= '0;
      prev_q       <= '1;
      sticky_rst_n <= 1'b0;
      ctrl_rst_n   <= 1'b0;
      phy_rst_n    <= 1'b0;
      stat_n       <= 1'b0;
    end else begin
      phase_q      <= phase_d;
      kind_q       <= kind_d;
      if (cnt_en) cnt_q <= cnt_d;
      prev_q       <= cur;
      sticky_rst_n <= sticky_d;
      ctrl_rst_n   <= ctrl_d;
      phy_rst_n    <= phy_d;
      stat_n       <= stat_d;
    end
  end
endmodule

// File: rtl/core_rst_seq.sv
module core_rst_seq #(
  parameter int NUM_CORES   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 16,
  parameter int STATUS_DLY  = 8
) (
  input  logic                 clk,
  input  logic                 board_rst_n,
  input  logic [NUM_CORES-1:0] cold_req_n,
  input  logic [NUM_CORES-1:0] warm_req_n,
  input  logic [NUM_CORES-1:0] phyclr_req_n,
  output logic [NUM_CORES-1:0] sticky_rst_n,
  output logic [NUM_CORES-1:0] ctrl_rst_n,
  output logic [NUM_CORES-1:0] phy_rst_n,
  output logic [NUM_CORES-1:0] rst_stat_n
);
  localparam int REQ_W = 3 * NUM_CORES;

  logic             grst_n;
  logic [REQ_W-1:0] req_raw;
  logic [REQ_W-1:0] req_s;

  crs_rst_sync #(.STAGES(SYNC_STAGES)) u_gsync (
    .clk    (clk),
    .arst_n (board_rst_n),
    .srst_n (grst_n)
  );

  assign req_raw = {phyclr_req_n, warm_req_n, cold_req_n};

  crs_req_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES)) u_rsync (
    .clk   (clk),
    .rst_n (grst_n),
    .din   (req_raw),
    .dout  (req_s)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    crs_core_seq #(.HOLD_CYC(HOLD_CYC), .STATUS_DLY(STATUS_DLY)) u_seq (
      .clk          (clk),
      .rst_n        (grst_n),
      .cold_s_n     (req_s[c]),
      .warm_s_n     (req_s[NUM_CORES + c]),
      .phy_s_n      (req_s[2*NUM_CORES + c]),
      .sticky_rst_n (sticky_rst_n[c]),
      .ctrl_rst_n   (ctrl_rst_n[c]),
      .phy_rst_n    (phy_rst_n[c]),
      .stat_n       (rst_stat_n[c])
    );
  end
endmodule

// File: rtl/core_rst_seq_chk.sv
module core_rst_seq_chk #(
  parameter int NUM_CORES = 2,
  parameter int HOLD_CYC  = 16
) (
  input logic                 clk,
  input logic                 board_rst_n,
  input logic [NUM_CORES-1:0] sticky_rst_n,
  input logic [NUM_CORES-1:0] ctrl_rst_n,
  input logic [NUM_CORES-1:0] phy_rst_n,
  input logic [NUM_CORES-1:0] rst_stat_n
);
  localparam int LW = $clog2(HOLD_CYC + 2);
  localparam logic [LW-1:0] LMAX = LW'(HOLD_CYC + 1);

  // R1
  global_hold_chk: assert property (@(posedge clk) disable iff (board_rst_n)
    1'b1 |-> (sticky_rst_n == '0) && (ctrl_rst_n == '0) && (phy_rst_n == '0) && (rst_stat_n == '0));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge board_rst_n) begin
      if (!board_rst_n)    low_cnt <= '0;
      else if (phy_rst_n[c]) low_cnt <= '0;
      else if (low_cnt != LMAX) low_cnt <= low_cnt + 1'b1;
    end

    // R12
    sticky_nest_chk: assert property (@(posedge clk) disable iff (!board_rst_n)
      !sticky_rst_n[c] |-> !ctrl_rst_n[c]);

    // R12
    ctrl_nest_chk: assert property (@(posedge clk) disable iff (!board_rst_n)
      !ctrl_rst_n[c] |-> !phy_rst_n[c]);

    // R9
    stat_low_chk: assert property (@(posedge clk) disable iff (!board_rst_n)
      (!sticky_rst_n[c] || !ctrl_rst_n[c] || !phy_rst_n[c]) |-> !rst_stat_n[c]);

    // R7
    hold_min_chk: assert property (@(posedge clk) disable iff (!board_rst_n)
      $rose(phy_rst_n[c]) |-> (low_cnt >= LW'(HOLD_CYC)));
  end
endmodule

bind core_rst_seq core_rst_seq_chk #(.NUM_CORES(NUM_CORES), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk          (clk),
  .board_rst_n  (board_rst_n),
  .sticky_rst_n (sticky_rst_n),
  .ctrl_rst_n   (ctrl_rst_n),
  .phy_rst_n    (phy_rst_n),
  .rst_stat_n   (rst_stat_n)
);

// File: tb/sim_core_rst_seq.sv
module sim_core_rst_seq;
  localparam int NC = 2;

  logic          clk;
  logic          board_rst_n;
  logic [NC-1:0] cold_req_n, warm_req_n, phyclr_req_n;
  logic [NC-1:0] sticky_rst_n, ctrl_rst_n, phy_rst_n, rst_stat_n;

  int checks = 0;
  int errs   = 0;

  core_rst_seq u0 (
    .clk          (clk),
    .board_rst_n  (board_rst_n),
    .cold_req_n   (cold_req_n),
    .warm_req_n   (warm_req_n),
    .phyclr_req_n (phyclr_req_n),
    .sticky_rst_n (sticky_rst_n),
    .ctrl_rst_n   (ctrl_rst_n),
    .phy_rst_n    (phy_rst_n),
    .rst_stat_n   (rst_stat_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: [6] core, [5] cold, [4] warm, [3] phy-clear (1 = pulse low),
  //         [2:0] expected {sticky, ctrl, phy} while held
  localparam logic [6:0] VEC [6] = '{
    7'b0_100_000,   // core0 cold
    7'b1_010_100,   // core1 warm
    7'b0_001_110,   // core0 phy clear
    7'b1_110_000,   // core1 cold+warm: cold wins
    7'b0_011_100,   // core0 warm+phy: warm wins
    7'b1_111_000    // core1 all three: cold wins
  };

  function automatic logic [3:0] outs(input int c);
    return {sticky_rst_n[c], ctrl_rst_n[c], phy_rst_n[c], rst_stat_n[c]};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic board_release;
    board_rst_n = 1'b1;
    wait_n(17);
    chk("R2 resets low on edge 17", outs(0), 4'b0000);
    wait_n(1);
    chk("R2 core0 resets high on edge 18", outs(0), 4'b1110);
    chk("R2 core1 resets high on edge 18", outs(1), 4'b1110);
    wait_n(7);
    chk("R2 status low on edge 25", outs(1), 4'b1110);
    wait_n(1);
    chk("R2 core0 status high on edge 26", outs(0), 4'b1111);
    chk("R2 core1 status high on edge 26", outs(1), 4'b1111);
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    int c;
    board_rst_n  = 1'b1;
    cold_req_n   = '1;
    warm_req_n   = '1;
    phyclr_req_n = '1;
    #1 board_rst_n = 1'b0;
    wait_n(4);
    // R1 reset state
    chk("R1 core0 in board reset", outs(0), 4'b0000);
    chk("R1 core1 in board reset", outs(1), 4'b0000);
    board_release();

    // R3 R4 R5 R6 R7 R9 R11 R12 vector table
    for (int i = 0; i < 6; i++) begin
      c = int'(VEC[i][6]);
      cold_req_n[c]   = ~VEC[i][5];
      warm_req_n[c]   = ~VEC[i][4];
      phyclr_req_n[c] = ~VEC[i][3];
      wait_n(2);
      chk("R3 R4 R5 not yet on edge 2", outs(c), 4'b1111);
      wait_n(1);
      chk("R3 R4 R5 R6 R12 held pattern", outs(c), {VEC[i][2:0], 1'b0});
      chk("R11 other core untouched", outs(1 - c), 4'b1111);
      cold_req_n   = '1;
      warm_req_n   = '1;
      phyclr_req_n = '1;
      wait_n(15);
      chk("R7 still held on cycle 16", outs(c), {VEC[i][2:0], 1'b0});
      wait_n(1);
      chk("R7 released after 16", outs(c), 4'b1110);
      wait_n(7);
      chk("R9 status still low", outs(c), 4'b1110);
      wait_n(1);
      chk("R9 status high 8 later", outs(c), 4'b1111);
      chk("R11 other core still up", outs(1 - c), 4'b1111);
    end

    // R8 long request on core1
    cold_req_n[1] = 1'b0;
    wait_n(30);
    chk("R8 held while request low", outs(1), 4'b0000);
    cold_req_n[1] = 1'b1;
    wait_n(2);
    chk("R8 still held edge 2 after rise", outs(1), 4'b0000);
    wait_n(1);
    chk("R8 released edge 3 after rise", outs(1), 4'b1110);
    wait_n(8);
    chk("R8 status back", outs(1), 4'b1111);

    // R10 requests while status low are ignored (core0)
    warm_req_n[0] = 1'b0;
    wait_n(3);
    chk("R10 warm reset started", outs(0), 4'b1000);
    warm_req_n[0] = 1'b1;
    cold_req_n[0] = 1'b0;           // falls during hold
    wait_n(2);
    cold_req_n[0] = 1'b1;
    wait_n(13);
    chk("R10 sticky untouched by cold in hold", outs(0), 4'b1000);
    wait_n(1);
    chk("R10 released on warm schedule", outs(0), 4'b1110);
    phyclr_req_n[0] = 1'b0;         // falls during settle
    wait_n(3);
    phyclr_req_n[0] = 1'b1;
    chk("R10 phy clear in settle ignored", outs(0), 4'b1110);
    wait_n(5);
    chk("R10 status on schedule", outs(0), 4'b1111);
    wait_n(5);
    chk("R10 no late reset", outs(0), 4'b1111);

    // R1 board pin overrides at once
    warm_req_n[1] = 1'b0;
    wait_n(3);
    board_rst_n = 1'b0;
    #1;
    chk("R1 core0 forced low asynchronously", outs(0), 4'b0000);
    chk("R1 core1 forced low asynchronously", outs(1), 4'b0000);
    warm_req_n[1] = 1'b1;
    wait_n(3);
    board_release();

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule